// File: doc/BRIEF.md
# Flow-Match Receive Destination Resolver

This block decides which output ring a received frame goes to once a flow-table lookup has finished. It takes the lookup result and the routing fields of the matched entry. It also takes two alternate destinations, one from an address/peer search and one from a classifier rule, and a handful of configuration inputs. It returns a final ring ID, one clock after the request.

The ring decision follows a fixed order of precedence:

1. A missing, invalid or stale match sends the frame to a configured default ring.
2. A drop request on the entry forces the release ring.
3. An offload request on the entry forces a programmed offload ring. This override can be suppressed for frames that span several buffers.
4. Otherwise a two-bit handler code chooses the source of the destination.

Destination codes that name rings this configuration does not implement are translated through a 32-entry remap table. That table is written through a simple write port.

Beside the ring, the block reports whether the flow search counted as successful for routing. In first-fragment mode it also signals that the matched entry's stale-destination bit must be set. After that, later matches on the same entry route as if the search had failed.

Top module: `flow_ring_resolver`

## Requirements
- R1: `res_valid` is high exactly one cycle after a cycle with `req_valid` high, and low otherwise. While `res_valid` is low, `res_found` and `res_mark_stale` are low.
- R2: A request counts as a hit only when `hit` and `ent_valid` are both 1. On a non-hit, `res_ring` equals `cfg_default_ring` and `res_found` is 0.
- R3: A hit whose entry has `ent_stale` = 1 gives `res_ring` = `cfg_default_ring` and `res_found` = 0.
- R4: With `cfg_first_frag` = 1, every hit, stale or not, raises `res_mark_stale`. With `cfg_first_frag` = 0, `res_mark_stale` stays 0.
- R5: A non-stale hit with `ent_drop` = 1 gives ring 5 (the release ring) and `res_found` = 1. This overrides the offload flag and the handler code.
- R6: A non-stale hit without drop and with `ent_offload` = 1 gives `res_ring` = `cfg_offload_ring` and `res_found` = 1. No remap is applied to that ring.
- R7: When `multi_buf` = 1 and `cfg_offload_mb_block` = 1, the offload flag has no effect, and routing follows the handler code.
- R8: On the handler path, `ent_handler` selects the raw code as follows, with `res_found` = 1:
  - 0 or 2 selects `ent_dest`;
  - 1 selects `peer_dest`;
  - 3 selects `rule_dest`.
- R9: Raw codes 0 to 6 are output unchanged. Raw codes 11 to 31 are always replaced by the remap table entry at that code.
- R10: Raw code 7+k (k = 0..3) is output unchanged when `cfg_hi_present[k]` is 1. Otherwise it is replaced by the remap table entry at that code.
- R11: Every remap table entry resets to 0. A write with `map_we` = 1 stores `map_data` at `map_addr`. A lookup in the same cycle still sees the old value, and lookups from the next cycle see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A lookup result is presented this cycle |
| hit | input | 1 | Lookup found a matching entry |
| ent_valid | input | 1 | Matched entry's valid bit |
| ent_dest | input | 5 | Entry's own destination code |
| ent_handler | input | 2 | Handler code choosing the destination source |
| ent_drop | input | 1 | Entry requests the release ring |
| ent_offload | input | 1 | Entry requests the offload ring |
| ent_stale | input | 1 | Entry's destination has been marked invalid |
| peer_dest | input | 5 | Destination from address/peer search |
| rule_dest | input | 5 | Destination from classifier rule |
| multi_buf | input | 1 | Frame needs more than one buffer |
| cfg_offload_ring | input | 5 | Programmed offload ring number |
| cfg_offload_mb_block | input | 1 | Suppress offload override for multi-buffer frames |
| cfg_first_frag | input | 1 | First-fragment mode |
| cfg_default_ring | input | 5 | Ring used when the search fails |
| cfg_hi_present | input | 4 | Presence of software rings for codes 7..10 |
| map_we | input | 1 | Remap table write enable |
| map_addr | input | 5 | Remap table write address |
| map_data | input | 5 | Remap table write data |
| res_valid | output | 1 | Result valid |
| res_ring | output | 5 | Final ring ID |
| res_found | output | 1 | Flow search counted as successful for routing |
| res_mark_stale | output | 1 | Matched entry's stale bit must be set |

## Verification
The bench builds the block with its default parameters: 5-bit ring codes and four optional software rings at codes 7..10. At that size the full code space can be swept. Every raw code from 0 to 31 passes through every handler code under three presence masks, including none present, all present and alternating. This covers the fixed, conditional and always-remapped bands of R9 and R10.

A second sweep covers all 256 combinations of the eight control flags, so the drop, offload, multi-buffer, stale and first-fragment precedence of R2 to R7 is checked exhaustively. A dedicated sequence writes the remap table in the same cycle as a lookup, which exposes the write-visibility rule of R11.

// File: rtl/flow_ring_resolver.sv
module flow_ring_resolver #(
  parameter int RING_W = 5,
  parameter int N_HI   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hit,
  input  logic              ent_valid,
  input  logic [RING_W-1:0] ent_dest,
  input  logic [1:0]        ent_handler,
  input  logic              ent_drop,
  input  logic              ent_offload,
  input  logic              ent_stale,
  input  logic [RING_W-1:0] peer_dest,
  input  logic [RING_W-1:0] rule_dest,
  input  logic              multi_buf,
  input  logic [RING_W-1:0] cfg_offload_ring,
  input  logic              cfg_offload_mb_block,
  input  logic              cfg_first_frag,
  input  logic [RING_W-1:0] cfg_default_ring,
  input  logic [N_HI-1:0]   cfg_hi_present,
  input  logic              map_we,
  input  logic [RING_W-1:0] map_addr,
  input  logic [RING_W-1:0] map_data,
  output logic              res_valid,
  output logic [RING_W-1:0] res_ring,
  output logic              res_found,
  output logic              res_mark_stale
);
  localparam int DEPTH = 1 << RING_W;
  localparam int HI_IW = (N_HI > 1) ? $clog2(N_HI) : 1;
  localparam logic [RING_W-1:0] RELEASE_RING = RING_W'(5);
  localparam logic [RING_W-1:0] HI_BASE      = RING_W'(7);
  localparam logic [RING_W-1:0] HI_END       = RING_W'(7 + N_HI);

  logic [RING_W-1:0] remap_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) remap_q[i] <= '0;
    end else if (map_we) begin
      remap_q[map_addr] <= map_data;
    end
  end

  wire match    = hit & ent_valid;
  wire usable   = match & ~ent_stale;
  wire offl_on  = ent_offload & ~(multi_buf & cfg_offload_mb_block);

  logic [RING_W-1:0] raw;
  always_comb begin
    case (ent_handler)
      2'd1:    raw = peer_dest;
      2'd3:    raw = rule_dest;
      default: raw = ent_dest;
    endcase
  end

  wire [RING_W-1:0] hi_off   = raw - HI_BASE;
  wire              in_hi    = (raw >= HI_BASE) && (raw < HI_END);
  wire              keep_raw = (raw < HI_BASE) ||
                               (in_hi && cfg_hi_present[hi_off[HI_IW-1:0]]);
  wire [RING_W-1:0] mapped   = keep_raw ? raw : remap_q[raw];

  logic [RING_W-1:0] ring_d;
  always_comb begin
    if (!usable)       ring_d = cfg_default_ring;
    else if (ent_drop) ring_d = RELEASE_RING;
    else if (offl_on)  ring_d = cfg_offload_ring;
    else               ring_d = mapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_ring       <= '0;
      res_found      <= 1'b0;
      res_mark_stale <= 1'b0;
    end else begin
      res_valid      <= req_valid;
      res_found      <= req_valid & usable;
      res_mark_stale <= req_valid & match & cfg_first_frag;
      if (req_valid) res_ring <= ring_d;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_found && !res_mark_stale));
  a_r2_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(hit && ent_valid)) |=> (!res_found && res_ring == $past(cfg_default_ring)));
  a_r3_stale_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ent_stale) |=> !res_found);
  a_r4_mark_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_first_frag) |=> !res_mark_stale);
  a_r5_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && ent_valid && !ent_stale && ent_drop) |=> (res_found && res_ring == RELEASE_RING));
  a_r6_offload_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && ent_valid && !ent_stale && !ent_drop && ent_offload && !multi_buf)
      |=> (res_ring == $past(cfg_offload_ring)));
endmodule

// File: tb/sim_flow_ring_resolver.sv
module sim_flow_ring_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, hit = 0, ent_valid = 0, ent_drop = 0, ent_offload = 0, ent_stale = 0;
  logic [4:0] ent_dest = 0, peer_dest = 0, rule_dest = 0;
  logic [1:0] ent_handler = 0;
  logic multi_buf = 0, cfg_offload_mb_block = 0, cfg_first_frag = 0;
  logic [4:0] cfg_offload_ring = 5'd12, cfg_default_ring = 5'd3;
  logic [3:0] cfg_hi_present = 4'hF;
  logic map_we = 0;
  logic [4:0] map_addr = 0, map_data = 0;
  logic res_valid, res_found, res_mark_stale;
  logic [4:0] res_ring;

  flow_ring_resolver u0 (.*);

  int compared = 0, mismatched = 0;
  logic [4:0] shadow [32];
  logic done = 0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [1:0] h, input logic [4:0] e, p, r);
    return (h == 2'd1) ? int'(p) : (h == 2'd3) ? int'(r) : int'(e);
  endfunction

  function automatic int route(input int code, input logic [3:0] mask);
    if (code < 7) return code;
    if (code < 11 && mask[code-7]) return code;
    return int'(shadow[code]);
  endfunction

  task automatic step_check(input string req);
    int er, ef, em;
    logic usable;
    usable = hit && ent_valid && !ent_stale;
    em = (hit && ent_valid && cfg_first_frag) ? 1 : 0;
    ef = usable ? 1 : 0;
    if (!usable) er = cfg_default_ring;
    else if (ent_drop) er = 5;
    else if (ent_offload && !(multi_buf && cfg_offload_mb_block)) er = cfg_offload_ring;
    else er = route(pick(ent_handler, ent_dest, peer_dest, rule_dest), cfg_hi_present);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " ring"}, res_ring, er);
    chk({req, " found"}, res_found, ef);
    chk({req, " mark"}, res_mark_stale, em);
  endtask

  task automatic wr(input logic [4:0] a, input logic [4:0] d);
    map_we = 1; map_addr = a; map_data = d;
    @(negedge clk);
    map_we = 0;
    shadow[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 5'd0;
    repeat (3) @(negedge clk);
    // reset state (R1, R11)
    chk("R1 reset valid", res_valid, 0);
    chk("R1 reset found", res_found, 0);
    chk("R1 reset mark", res_mark_stale, 0);
    rst_n = 1;
    @(negedge clk);
    hit = 1; ent_valid = 1; ent_handler = 0; ent_dest = 5'd20;
    step_check("R11 reset table entry");
    for (int a = 0; a < 32; a++) wr(5'(a), 5'((a * 11 + 6) % 32));

    // R8 R9 R10 sweep: handler x code x presence mask
    for (int m = 0; m < 3; m++) begin
      cfg_hi_present = (m == 0) ? 4'hF : (m == 1) ? 4'h0 : 4'b0101;
      for (int h = 0; h < 4; h++) begin
        for (int c = 0; c < 32; c++) begin
          ent_handler = 2'(h);
          ent_dest = 5'(c); peer_dest = 5'(c) ^ 5'd9; rule_dest = 5'(c) ^ 5'd21;
          step_check("R8/R9/R10 handler+remap");
        end
      end
    end

    // R2 R3 R4 R5 R6 R7 exhaustive flags
    cfg_hi_present = 4'b0011;
    for (int f = 0; f < 256; f++) begin
      hit = f[0]; ent_valid = f[1]; ent_stale = f[2]; ent_drop = f[3];
      ent_offload = f[4]; multi_buf = f[5]; cfg_offload_mb_block = f[6]; cfg_first_frag = f[7];
      ent_handler = 2'(f % 4);
      ent_dest = 5'(f % 32); peer_dest = 5'((f + 3) % 32); rule_dest = 5'((f + 17) % 32);
      cfg_default_ring = 5'((f * 3) % 32);
      step_check("R2/R3/R4/R5/R6/R7 flags");
    end

    // R1 idle cycle
    @(negedge clk);
    chk("R1 idle valid", res_valid, 0);
    chk("R1 idle found", res_found, 0);
    chk("R1 idle mark", res_mark_stale, 0);

    // R11 write and lookup in the same cycle
    hit = 1; ent_valid = 1; ent_stale = 0; ent_drop = 0; ent_offload = 0;
    cfg_first_frag = 0; ent_handler = 0; ent_dest = 5'd25;
    map_we = 1; map_addr = 5'd25; map_data = 5'd2; req_valid = 1;
    @(negedge clk);
    map_we = 0; req_valid = 0;
    chk("R11 same-cycle old value", res_ring, int'(shadow[25]));
    shadow[25] = 5'd2;
    step_check("R11 new value visible");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule